// File: doc/BRIEF.md
# Mode-Switchable Round-Robin Bus Arbiter

This block arbitrates a shared backplane bus among eight requesters: seven backplane slots and one local bridge. When the board acts as the bus controller, it hands out one grant at a time in rotating order. A new decision is taken only when the bus is idle or when the current owner withdraws its request. With nobody asking for the bus, the grant rests on the local bridge.

When the board sits in a satellite slot, the arbiter stops granting. It then behaves as a plain wire: the local bridge request leaves on the upstream request 0 line, and the upstream grant 0 comes back as the bridge grant. Whenever the mode input changes, all grants are withdrawn for one cycle before the new behaviour takes over.

Top module: `rr_bus_arbiter`

## Requirements
- R1: While reset is low, every grant output and `upReq0N` are high (inactive), and the block comes out of reset in controller mode with the rotation pointer at index 0.
- R2: At most one of the eight grant outputs (`slotGntN[6:0]`, `bridgeGntN`) is low in any cycle.
- R3: In controller mode the winner is the first requester with its request low, searching from the pointer in increasing index order with wrap-around. Slots 0..6 are indices 0..6 and the bridge is index 7. After a win, the pointer moves to winner+1 modulo 8.
- R4: A new decision is taken only at a clock edge where the bus is idle (`frameN` and `irdyN` both high) or the current owner's request is high. Otherwise the grant is held unchanged.
- R5: When a decision is taken and no request is low, the grant goes to the bridge (index 7) and the pointer does not move.
- R6: Grants are registered: a decision taken at a clock edge from the inputs sampled there is visible on the grant outputs just after that edge.
- R7: In satellite mode `slotGntN` is all high, `upReq0N` follows `bridgeReqN`, and `bridgeGntN` follows `upGnt0N`, both without a clock delay. In controller mode `upReq0N` is held high.
- R8: `satMode` is sampled at each clock edge. After an edge that sees it differ from the current mode, all grants and `upReq0N` are high for one cycle. The new mode acts from the following edge, and controller mode then begins with no grant until its first decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| satMode | input | 1 | 1 = satellite (pass-through), 0 = bus controller |
| slotReqN | input | 7 | Backplane slot requests, active low, bit i = slot i |
| bridgeReqN | input | 1 | Local bridge request, active low |
| frameN | input | 1 | Bus cycle frame, active low |
| irdyN | input | 1 | Initiator ready, active low |
| upGnt0N | input | 1 | Upstream grant 0 seen in satellite mode, active low |
| slotGntN | output | 7 | Backplane slot grants, active low |
| bridgeGntN | output | 1 | Local bridge grant, active low |
| upReq0N | output | 1 | Upstream request 0 driven in satellite mode, active low |

## Verification
The assertions take for granted that the requests, bus-state lines and mode input are stable around each rising clock edge, and that a requester only drops its request on its own schedule, with no link to the grant. The bench changes every input only on the falling edge. It holds `satMode` steady across long stretches so that each mode change is followed by a full blanking cycle before the next one. It drives busy-bus cycles (`frameN` low) only while a grant is held, so the hold and re-decision cases each arise on purpose.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
  // Strobes sent from the control module to the grant datapath.
  typedef struct packed {
    logic clrGrant;  // drop any grant held
    logic reArb;     // take a new decision at this edge
  } arbStrobe_t;
endpackage

// File: rtl/rr_arb_ctrl.sv
module rr_arb_ctrl
  import rr_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       satMode,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       ownerHold,
  output arbStrobe_t strobe,
  output logic       modeQ,
  output logic       blankQ
);
  logic modeChange;
  logic busIdle;

  assign modeChange = (satMode != modeQ);
  assign busIdle    = frameN & irdyN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      blankQ <= 1'b0;
    end else begin
      modeQ  <= satMode;
      blankQ <= modeChange;
    end
  end

  always_comb begin
    strobe.clrGrant = blankQ | modeQ | modeChange;
    strobe.reArb    = busIdle | ~ownerHold;
  end

  // R8: a blanking cycle always follows a sensed mode change
  a_r8_blank_follows: assert property (@(posedge clk) disable iff (!rstN)
    modeChange |=> blankQ);
endmodule

// File: rtl/rr_arb_dp.sv
module rr_arb_dp
  import rr_arb_pkg::*;
#(
  parameter int NREQ = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  arbStrobe_t      strobe,
  input  logic [NREQ-1:0] reqN,
  output logic [NREQ-1:0] gntQ,
  output logic            ownerHold
);
  localparam int PTRW = $clog2(NREQ);
  localparam logic [PTRW:0] NREQ_W = (PTRW+1)'(NREQ);
  localparam logic [NREQ-1:0] PARK_OH = {1'b1, {(NREQ-1){1'b0}}};

  logic [PTRW-1:0] ptrQ;
  logic [PTRW-1:0] pickIdx;
  logic [PTRW-1:0] nextPtr;
  logic [NREQ-1:0] pickOH;
  logic            found;
  logic [PTRW:0]   idx;

  always_comb begin
    pickOH  = '0;
    pickIdx = '0;
    found   = 1'b0;
    idx     = '0;
    for (int i = 0; i < NREQ; i++) begin
      idx = {1'b0, ptrQ} + (PTRW+1)'(i);
      if (idx >= NREQ_W) idx = idx - NREQ_W;
      if (!found && !reqN[idx[PTRW-1:0]]) begin
        found                 = 1'b1;
        pickIdx               = idx[PTRW-1:0];
        pickOH[idx[PTRW-1:0]] = 1'b1;
      end
    end
  end

  assign nextPtr   = (pickIdx == PTRW'(NREQ-1)) ? '0 : pickIdx + 1'b1;
  assign ownerHold = |(gntQ & ~reqN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gntQ <= '0;
      ptrQ <= '0;
    end else if (strobe.clrGrant) begin
      gntQ <= '0;
    end else if (strobe.reArb) begin
      if (found) begin
        gntQ <= pickOH;
        ptrQ <= nextPtr;
      end else begin
        gntQ <= PARK_OH;
      end
    end
  end

  // R5: an empty decision parks on the bridge
  a_r5_park: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrGrant && strobe.reArb && (&reqN)) |=> (gntQ == PARK_OH));
  // R3: a decision with requests pending lands on a requester
  a_r3_to_requester: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrGrant && strobe.reArb && !(&reqN)) |=> |(gntQ & ~$past(reqN)));
  // R4: no decision means the grant is held
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrGrant && !strobe.reArb) |=> $stable(gntQ));
endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter
  import rr_arb_pkg::*;
#(
  parameter int NSLOTS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              satMode,
  input  logic [NSLOTS-1:0] slotReqN,
  input  logic              bridgeReqN,
  input  logic              frameN,
  input  logic              irdyN,
  input  logic              upGnt0N,
  output logic [NSLOTS-1:0] slotGntN,
  output logic              bridgeGntN,
  output logic              upReq0N
);
  localparam int NREQ = NSLOTS + 1;

  arbStrobe_t      strobe;
  logic            modeQ;
  logic            blankQ;
  logic            ownerHold;
  logic [NREQ-1:0] gntQ;
  logic            passOn;

  rr_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .satMode(satMode), .frameN(frameN),
    .irdyN(irdyN), .ownerHold(ownerHold), .strobe(strobe),
    .modeQ(modeQ), .blankQ(blankQ)
  );

  rr_arb_dp #(.NREQ(NREQ)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqN({bridgeReqN, slotReqN}), .gntQ(gntQ), .ownerHold(ownerHold)
  );

  assign passOn     = modeQ & ~blankQ;
  assign slotGntN   = ~gntQ[NSLOTS-1:0];
  assign bridgeGntN = passOn ? upGnt0N : ~gntQ[NREQ-1];
  assign upReq0N    = passOn ? bridgeReqN : 1'b1;

  // R2: one grant at most
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~{bridgeGntN, slotGntN}));
  // R7: satellite mode never grants a slot
  a_r7_no_slot_grant: assert property (@(posedge clk) disable iff (!rstN)
    modeQ |-> (&slotGntN));
  // R8: everything released in the cycle after a sensed mode change
  a_r8_gap: assert property (@(posedge clk) disable iff (!rstN)
    (satMode != modeQ) |=> ((&slotGntN) && bridgeGntN && upReq0N));
endmodule

// File: tb/rr_bus_arbiter_tb.sv
module rr_bus_arbiter_tb;
  typedef struct {
    logic [6:0] slot;
    logic       br;
    logic       up;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       satMode = 1'b0;
  logic [6:0] slotReqN = 7'h7f;
  logic       bridgeReqN = 1'b1;
  logic       frameN = 1'b1;
  logic       irdyN = 1'b1;
  logic       upGnt0N = 1'b1;
  logic [6:0] slotGntN;
  logic       bridgeGntN;
  logic       upReq0N;

  int checks = 0;
  int errors = 0;
  expItem_t q[$];

  int mOwner = -1;
  int mPtr = 0;
  bit mMode = 0;
  bit mBlank = 0;

  always #2 clk = ~clk;

  rr_bus_arbiter u_dut (
    .clk(clk), .rstN(rstN), .satMode(satMode), .slotReqN(slotReqN),
    .bridgeReqN(bridgeReqN), .frameN(frameN), .irdyN(irdyN),
    .upGnt0N(upGnt0N), .slotGntN(slotGntN), .bridgeGntN(bridgeGntN),
    .upReq0N(upReq0N)
  );

  // Model of the next edge built from the requirements, result queued.
  task automatic drive(input logic [6:0] s, input logic b, input logic f,
                       input logic ir, input logic sm, input logic ug,
                       input string tag);
    logic [7:0] req;
    bit mism, clr, hold, rearb, got;
    expItem_t e;
    slotReqN = s; bridgeReqN = b; frameN = f; irdyN = ir;
    satMode = sm; upGnt0N = ug;
    req  = {b, s};
    mism = (sm != mMode);
    clr  = mBlank || mMode || mism;
    hold = (mOwner >= 0) && (req[mOwner] == 1'b0);
    rearb = !hold || (f && ir);
    if (clr) mOwner = -1;
    else if (rearb) begin
      got = 0;
      for (int i = 0; i < 8; i++) begin
        int k;
        k = (mPtr + i) % 8;
        if (!got && req[k] == 1'b0) begin
          got = 1; mOwner = k; mPtr = (k + 1) % 8;
        end
      end
      if (!got) mOwner = 7;
    end
    mBlank = mism;
    mMode  = sm;
    e.slot = 7'h7f; e.br = 1'b1; e.up = 1'b1; e.tag = tag;
    if (mMode && !mBlank) begin
      e.br = ug; e.up = b;
    end else if (!mMode && mOwner >= 0) begin
      if (mOwner == 7) e.br = 1'b0;
      else e.slot[mOwner] = 1'b0;
    end
    q.push_back(e);
  endtask

  task automatic cyc(input logic [6:0] s, input logic b, input logic f,
                     input logic ir, input logic sm, input logic ug,
                     input string tag);
    @(negedge clk);
    drive(s, b, f, ir, sm, ug, tag);
  endtask

  // Monitor: pops one expected item per edge and compares.
  always @(posedge clk) begin
    #1;
    if (rstN && q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      checks++;
      if (slotGntN !== e.slot || bridgeGntN !== e.br || upReq0N !== e.up) begin
        errors++;
        $display("FAIL %s: got slot=%h br=%b up=%b expected slot=%h br=%b up=%b",
                 e.tag, slotGntN, bridgeGntN, upReq0N, e.slot, e.br, e.up);
      end
      checks++;
      if ($countones(~{bridgeGntN, slotGntN}) > 1) begin
        errors++;
        $display("FAIL R2: got grants=%b expected at most one low",
                 {bridgeGntN, slotGntN});
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (slotGntN !== 7'h7f || bridgeGntN !== 1'b1 || upReq0N !== 1'b1) begin
      errors++;
      $display("FAIL R1: got slot=%h br=%b up=%b expected 7f 1 1",
               slotGntN, bridgeGntN, upReq0N);
    end
    rstN = 1'b1;
    // R5/R6: no requests, grant parks on bridge after first edge
    drive(7'h7f, 1, 1, 1, 0, 1, "R5");
    cyc(7'h7f, 1, 1, 1, 0, 1, "R5");
    // R3: slot 2 asks, parked bridge not asking so decision taken
    cyc(7'b1111011, 1, 0, 0, 0, 1, "R3");
    // R4: bus busy, owner 2 still asking, others asking: held
    cyc(7'b1001011, 1, 0, 1, 0, 1, "R4");
    cyc(7'b1001011, 1, 1, 0, 0, 1, "R4");
    // R3: bus idle, rotation 4, 5, then wrap to 2
    cyc(7'b1001011, 1, 1, 1, 0, 1, "R3");
    cyc(7'b1001011, 1, 1, 1, 0, 1, "R3");
    cyc(7'b1001011, 1, 1, 1, 0, 1, "R3");
    // R4: busy bus but owner drops request: new decision
    cyc(7'b1001111, 1, 0, 0, 0, 1, "R4");
    cyc(7'b1001111, 1, 0, 0, 0, 1, "R4");
    // R3: bridge joins, all slots ask; rotation includes index 7
    for (int n = 0; n < 10; n++) cyc(7'h00, 0, 1, 1, 0, 1, "R3");
    // R5: requests gone while bus idle
    cyc(7'h7f, 1, 1, 1, 0, 1, "R5");
    cyc(7'h7f, 1, 0, 0, 0, 1, "R5");
    // R8: switch to satellite, gap, then pass-through
    cyc(7'h00, 0, 1, 1, 1, 0, "R8");
    cyc(7'h00, 0, 1, 1, 1, 0, "R8");
    // R7: pass-through follows bridge request and upstream grant
    cyc(7'h00, 0, 1, 1, 1, 1, "R7");
    cyc(7'h00, 1, 1, 1, 1, 0, "R7");
    cyc(7'h7f, 0, 0, 0, 1, 0, "R7");
    cyc(7'h7f, 1, 1, 1, 1, 1, "R7");
    // R8: back to controller mode: gap then arbitration restarts
    cyc(7'b1111110, 1, 1, 1, 0, 0, "R8");
    cyc(7'b1111110, 1, 1, 1, 0, 0, "R8");
    cyc(7'b1111110, 1, 1, 1, 0, 0, "R8");
    cyc(7'b0111110, 1, 1, 1, 0, 0, "R3");
    cyc(7'b0111110, 1, 1, 1, 0, 0, "R3");
    cyc(7'h7f, 1, 1, 1, 0, 0, "R5");
    repeat (3) @(posedge clk);
    #2;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule